// File: doc/BRIEF.md
# Bit-Serial Signed Multiplier

This block forms the two's complement product of two signed N-bit operands. It works through the multiplier one bit per clock. On a start request, both operands are captured in parallel and the multiplier is shifted out internally, least significant bit first.

On each step the block widens the multiplicand with copies of its sign bit. It adds that value to a running partial sum when the current multiplier bit is 1, or adds nothing when the bit is 0. The multiplier's sign bit has negative weight, so on that final step the multiplicand is subtracted instead. After each step the sum moves one place to the right with its sign kept, and the bit that falls off the bottom leaves the block as the next product bit.

After N steps the low half of the product has come out serially. The high half is then shown in parallel, and a one-cycle completion pulse marks that moment.

Top module: `serial_smul`

## Requirements
- R1: While reset is asserted, and on the first cycles after its release, `prod_bit_vld` and `done` are 0.
- R2: A `start` sampled high at a rising edge with no operation running begins an operation. `prod_bit_vld` is then high for exactly the N clock cycles that follow the next N rising edges, and low at all other times.
- R3: During the k-th valid cycle (k = 0 … N-1), `prod_bit` equals bit k of the 2N-bit signed product `mcand * mplier`, least significant bit first.
- R4: `done` is high for exactly one cycle, which is the cycle of the last valid product bit. In that cycle `prod_hi` equals bits 2N-1 … N of the product.
- R5: A multiplier whose sign bit is 1 is treated as negative: its sign-bit step subtracts the multiplicand, and the product is correct.
- R6: A negative multiplicand is sign-extended before it is combined with the partial sum, so the products of -127 and -128 with any multiplier are correct.
- R7: The product of the most negative value in both operands (-2^(N-1) squared) is correct in both its serial and its parallel parts.
- R8: `start` is ignored while an operation is running: it neither restarts the operation nor changes its output bits or its valid-cycle count.
- R9: An operation may start on the rising edge right after the cycle in which `done` is high, with no idle cycle in between.
- R10: Operands are sampled only when a start is accepted. Changes to `mcand` or `mplier` during an operation do not affect its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| start | input | 1 | Request to begin a multiply; honoured only when idle |
| mcand | input | N | Signed multiplicand, captured at an accepted start |
| mplier | input | N | Signed multiplier, captured at an accepted start and serialized inside the block |
| prod_bit | output | 1 | Current product bit, LSB first |
| prod_bit_vld | output | 1 | `prod_bit` holds a product bit this cycle |
| done | output | 1 | One-cycle pulse with the last serial bit; `prod_hi` is valid |
| prod_hi | output | N | Upper N bits of the 2N-bit product, valid while `done` is high |

## Verification
A start accepted at edge t0 produces product bit k after edge t0+k+1, so the last serial bit, `done` and `prod_hi` all appear after edge t0+N. The first cycle after t0 and the cycle after t0+N+1 show no valid bit. The bench drives and samples only on falling clock edges. Its reference model steps one cycle at a time from the accepted start and compares every output on every one of those cycles. Operations run back to back with start held high and operands changed mid-operation, so the checks cover both the ignore rules and the rule that a new start is taken right after done.

// File: rtl/serial_smul_pkg.sv
package serial_smul_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } smul_state_e;

endpackage

// File: rtl/smul_rst_sync.sv
module smul_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[1];

endmodule

// File: rtl/smul_ctl.sv
module smul_ctl
  import serial_smul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic done
);

  localparam int CW = (N > 2) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(N - 1);

  smul_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic done_q, done_d;
  logic cnt_en;

  assign load = start && (state_q == ST_IDLE);
  assign step = (state_q == ST_RUN);
  assign last = step && (cnt_q == LAST_IDX);

  always_comb begin
    state_d = state_q;
    cnt_en  = 1'b0;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          cnt_en  = 1'b1;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        cnt_en = 1'b1;
        if (cnt_q == LAST_IDX) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign done = done_q;

  // R2: an accepted start leads to a running step on the next cycle
  a_r2_load_runs: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> step);

  // R4: the last step is followed by the done pulse and a return to idle
  a_r4_last_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (done && !step));

  // R4: done is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/smul_serializer.sv
module smul_serializer #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [N-1:0] din,
  output logic         bit_o
);

  logic [N-1:0] sr_q, sr_d;
  logic         sr_en;

  always_comb begin
    sr_en = load || step;
    if (load) sr_d = din;
    else      sr_d = {1'b0, sr_q[N-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign bit_o = sr_q[0];

  // R10: the first bit presented is the LSB of the operand captured at start
  a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (bit_o == $past(din[0])));

endmodule

// File: rtl/smul_datapath.sv
module smul_datapath #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         last,
  input  logic         mbit,
  input  logic [N-1:0] mcand,
  output logic         pbit,
  output logic         pvld,
  output logic [N-1:0] hi
);

  localparam int AW = N + 1;
  localparam int SW = N + 2;

  logic [N-1:0]  mc_q;
  logic [AW-1:0] acc_q, acc_d;
  logic          pbit_q, pbit_d;
  logic          pvld_q, pvld_d;
  logic [SW-1:0] mc_ext, acc_ext, addend, sum;
  logic          acc_en;

  always_comb begin
    mc_ext  = {{2{mc_q[N-1]}}, mc_q};
    acc_ext = {acc_q[AW-1], acc_q};
    if (!mbit)     addend = '0;
    else if (last) addend = (~mc_ext) + SW'(1);
    else           addend = mc_ext;
    sum    = acc_ext + addend;
    acc_en = load || step;
    if (load) acc_d = '0;
    else      acc_d = sum[SW-1:1];
    pbit_d = step ? sum[0] : 1'b0;
    pvld_d = step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_q   <= '0;
      acc_q  <= '0;
      pbit_q <= 1'b0;
      pvld_q <= 1'b0;
    end else begin
      if (load)   mc_q  <= mcand;
      if (acc_en) acc_q <= acc_d;
      pbit_q <= pbit_d;
      pvld_q <= pvld_d;
    end
  end

  assign pbit = pbit_q;
  assign pvld = pvld_q;
  assign hi   = acc_q[N-1:0];

  // R3: a zero multiplier bit emits the bit already at the bottom of the sum
  a_r3_zero_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !mbit) |=> (pbit == $past(acc_q[0])));

  // R2: a valid bit follows every step and nothing else
  a_r2_vld_follows_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> pvld);

  // R2: a fresh operation starts from an empty partial sum
  a_r2_clear_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (acc_q == '0));

endmodule

// File: rtl/serial_smul.sv
module serial_smul #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         start,
  input  logic [N-1:0] mcand,
  input  logic [N-1:0] mplier,
  output logic         prod_bit,
  output logic         prod_bit_vld,
  output logic         done,
  output logic [N-1:0] prod_hi
);

  logic rst_n;
  logic load, step, last, mbit;

  smul_rst_sync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  smul_ctl #(.N(N)) u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .step  (step),
    .last  (last),
    .done  (done)
  );

  smul_serializer #(.N(N)) u_ser (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .din   (mplier),
    .bit_o (mbit)
  );

  smul_datapath #(.N(N)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .last  (last),
    .mbit  (mbit),
    .mcand (mcand),
    .pbit  (prod_bit),
    .pvld  (prod_bit_vld),
    .hi    (prod_hi)
  );

  // R4: done coincides with the final valid product bit
  a_r4_done_with_vld: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> prod_bit_vld);

  // R2: no valid bit in the cycle after done unless a step is running
  a_r2_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !prod_bit_vld);

  // R1: outputs quiet during reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!prod_bit_vld && !done));

endmodule

// File: tb/test_serial_smul.sv
module test_serial_smul;

  localparam int N = 8;

  logic         clk;
  logic         arst_n;
  logic         start;
  logic [N-1:0] mcand;
  logic [N-1:0] mplier;
  logic         prod_bit;
  logic         prod_bit_vld;
  logic         done;
  logic [N-1:0] prod_hi;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  serial_smul #(.N(N)) i_serial_smul (
    .clk          (clk),
    .arst_n       (arst_n),
    .start        (start),
    .mcand        (mcand),
    .mplier       (mplier),
    .prod_bit     (prod_bit),
    .prod_bit_vld (prod_bit_vld),
    .done         (done),
    .prod_hi      (prod_hi)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Idle cycle: no valid bit and no done (R2, R4)
  task automatic idle_cycle();
    start = 1'b0;
    @(negedge clk);
    chk("R2 idle vld", longint'(prod_bit_vld), 0);
    chk("R4 idle done", longint'(done), 0);
  endtask

  // Called at a falling edge; runs one operation and returns at a falling edge
  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b,
                        input bit noisy, input string tag);
    longint p;
    p = longint'($signed(a)) * longint'($signed(b));
    start  = 1'b1;
    mcand  = a;
    mplier = b;
    @(negedge clk);
    chk({tag, " R2 no bit yet"}, longint'(prod_bit_vld), 0);
    chk({tag, " R4 no done yet"}, longint'(done), 0);
    start = noisy;
    if (noisy) begin
      mcand  = ~a;
      mplier = b ^ 8'h5A;
    end
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      chk({tag, " R2 vld"}, longint'(prod_bit_vld), 1);
      chk({tag, " R3 bit"}, longint'(prod_bit), longint'(p[k]));
      chk({tag, " R4 done"}, longint'(done), (k == N - 1) ? 1 : 0);
      if (k == N - 1) begin
        chk({tag, " R4 hi"}, longint'(prod_hi), longint'(p[2*N-1 -: N]));
        start = 1'b0;
      end else if (noisy) begin
        start  = (k % 2 == 0);
        mcand  = mcand + 8'd37;
        mplier = mplier - 8'd11;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    arst_n = 1'b0;
    start  = 1'b0;
    mcand  = '0;
    mplier = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset vld", longint'(prod_bit_vld), 0);
    chk("R1 reset done", longint'(done), 0);
    arst_n = 1'b1;
    @(negedge clk);
    chk("R1 release vld", longint'(prod_bit_vld), 0);
    chk("R1 release done", longint'(done), 0);
    repeat (3) @(negedge clk);

    run_op(8'd7, 8'd5, 0, "basic");
    idle_cycle();
    run_op(8'hF9, 8'd6, 0, "R6 neg mcand");
    idle_cycle();
    run_op(8'd6, 8'hF9, 0, "R5 neg mplier");
    idle_cycle();
    run_op(8'h81, 8'd1, 0, "R6 -127x1");
    idle_cycle();
    run_op(8'h81, 8'hFF, 0, "R6 -127x-1");
    idle_cycle();
    run_op(8'h80, 8'h80, 0, "R7 min*min");
    idle_cycle();
    run_op(8'h7F, 8'h80, 0, "R5 max*min");
    idle_cycle();
    run_op(8'h80, 8'h7F, 0, "R6 min*max");
    idle_cycle();
    run_op(8'hFF, 8'hFF, 0, "R5 -1*-1");
    idle_cycle();
    run_op(8'h00, 8'h80, 0, "R3 zero");
    idle_cycle();
    run_op(8'h81, 8'h93, 1, "R8 R10 noisy");
    run_op(8'h80, 8'h80, 1, "R9 back2back");
    run_op(8'h5C, 8'hA7, 0, "R9 chained");
    idle_cycle();
    for (int i = 0; i < 40; i++) begin
      run_op(N'($urandom), N'($urandom), (i % 3 == 0), "R3 random");
      if (i % 2 == 0) idle_cycle();
    end
    idle_cycle();
    finish_run();
  end

endmodule